// File: doc/BRIEF.md
# Wrapping DMA Address Sequencer

This block produces the address for one side of a DMA channel. Software writes a 32-bit sequence word that selects the bus width, an optional wrap window, a burst length, a byte-swap request and a double-buffer request. It then writes a start pointer. Each accepted word transfer moves the pointer forward by the bus width in bytes. When a wrap window is set, the pointer returns to the start pointer after the window's number of words. The block only generates addresses. It does not move data and has no bus handshake.

The parameter `MEM_SIDE` picks one of two variants. The peripheral variant (0) uses small wrap windows and ignores the burst and double-buffer fields. The memory variant (1) uses large wrap windows and decodes the burst and double-buffer fields. A small state machine controls when the pointer may move:

- `ST_IDLE`: after reset, until the first pointer write.
- `ST_RUN`: the configuration is legal and transfers advance the pointer.
- `ST_HALT`: the configuration is illegal and the pointer is held.

The transitions are:

- `IDLE_TO_RUN`: a pointer write while the configuration is legal.
- `IDLE_TO_HALT`: a pointer write while the configuration is illegal.
- `RUN_TO_HALT`: a sequence write that makes the configuration illegal.
- `HALT_TO_RUN`: a sequence write that makes it legal again.

Every transition judges the configuration as it will stand after the current write.

Top module: `wdma_addr_seq`

## Requirements
- R1: After reset `addr` is 0 and `wrap_pulse` is 0. The reset sequence word has width code 0 and, on the memory side, burst code 4, so `cfg_err` is 0, `step_bytes` is 1 and `wrap_words` is 0. Transfers before the first pointer write leave `addr` at 0.
- R2: The width code is in sequence bits 30:28. Codes 0, 1, 2, 3 and 4 give `step_bytes` of 1, 2, 4, 8 and 16.
- R3: In the run state, each cycle with `xfer` high and no pointer write advances `addr` by `step_bytes` one cycle later, unless a wrap occurs.
- R4: The wrap code is in sequence bits 18:16. On the peripheral side, codes 0 to 7 give `wrap_words` of 0 (no wrap), 1, 2, 4, 8, 16, 32 and 64.
- R5: On the memory side, wrap codes 0 to 7 give `wrap_words` of 0, 32, 64, 128, 256, 512, 1024 and 2048.
- R6: A transfer wraps when `wrap_words` is nonzero and the word count since the last pointer write has reached `wrap_words`-1. On a wrapping transfer, `addr` returns to the base captured at the last pointer write, and `wrap_pulse` is high for exactly that one following cycle.
- R7: A pointer write loads `addr` and the base and clears the word count. It takes priority over a transfer in the same cycle.
- R8: Width codes 5 to 7 raise `cfg_err`. While `cfg_err` is high, transfers leave `addr` unchanged. After a legal word is written, transfers resume from the held address.
- R9: On the memory side, burst codes 4, 5 and 6 in bits 26:24 give `burst_words` of 1, 4 and 8, and any other burst code raises `cfg_err`. On the peripheral side, the burst field is ignored: `burst_words` is 0 and the field never raises `cfg_err`.
- R10: Bit 27 drives `byte_swap` on both sides. Bit 19 drives `dbl_buf` on the memory side only; on the peripheral side `dbl_buf` is 0.
- R11: With wrap code 0, the pointer advances with no wrap and `wrap_pulse` stays low.
- R12: If a new wrap window is at or below the word count already reached, the next transfer wraps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| seq_wr | input | 1 | Write strobe for the sequence word |
| seq_data | input | 32 | Sequence word |
| ptr_wr | input | 1 | Write strobe for the start pointer |
| ptr_data | input | ADDR_W | Start pointer value |
| xfer | input | 1 | One word transfer accepted this cycle |
| addr | output | ADDR_W | Current address |
| step_bytes | output | 5 | Bytes per word, decoded from the width code |
| burst_words | output | 4 | Burst length in words (memory side) |
| byte_swap | output | 1 | Byte swap requested |
| dbl_buf | output | 1 | Double-buffer requested (memory side) |
| wrap_words | output | 12 | Wrap window in words, 0 means no wrap |
| cfg_err | output | 1 | Illegal width or burst code |
| wrap_pulse | output | 1 | One-cycle flag after a wrapping transfer |

## Verification
The bench sweeps every wrap code on both variants and runs one whole window plus a few extra words, so the 1-word window and the 2048-word window are both crossed. An off-by-one compare would wrap a word early or late, and a reload to the wrong base would show as a wrong address right after the pulse. It also writes a pointer and a transfer in the same cycle, and shrinks the window below the count already reached. A design that compared for equality would then run on without wrapping. Illegal width and burst codes are each checked on the side they affect. A design that skipped the hold would move the pointer, and one that checked burst codes on the peripheral side would flag a false error.

// File: rtl/wdma_pkg.sv
package wdma_pkg;

    localparam int SEQ_W   = 32;
    localparam int WRAP_W  = 12;
    localparam int STEP_W  = 5;
    localparam int BURST_W = 4;

    // Field positions decoded by the channel's neighbours.
    localparam int WIDTH_LSB = 28;
    localparam int SWAP_BIT  = 27;
    localparam int BURST_LSB = 24;
    localparam int DBUF_BIT  = 19;
    localparam int WRAP_LSB  = 16;

    localparam logic [2:0] WIDTH_MAX_CODE = 3'd4;
    localparam logic [2:0] BURST_LO_CODE  = 3'd4;
    localparam logic [2:0] BURST_HI_CODE  = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HALT = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic [2:0] width;
        logic       swap;
        logic [2:0] burst;
        logic       dbuf;
        logic [2:0] wrap;
    } seq_fields_t;

    function automatic seq_fields_t fields_of(input logic [SEQ_W-1:0] w);
        seq_fields_t f;
        f.width = w[WIDTH_LSB +: 3];
        f.swap  = w[SWAP_BIT];
        f.burst = w[BURST_LSB +: 3];
        f.dbuf  = w[DBUF_BIT];
        f.wrap  = w[WRAP_LSB +: 3];
        return f;
    endfunction

    function automatic logic fields_bad(input bit mem_side, input seq_fields_t f);
        logic burst_bad;
        burst_bad = (f.burst < BURST_LO_CODE) || (f.burst > BURST_HI_CODE);
        return (f.width > WIDTH_MAX_CODE) || (mem_side && burst_bad);
    endfunction

    function automatic logic [WRAP_W-1:0] wrap_size(input bit mem_side, input logic [2:0] code);
        logic [WRAP_W-1:0] unit;
        unit = mem_side ? WRAP_W'(32) : WRAP_W'(1);
        if (code == 3'd0) return '0;
        return unit << (code - 3'd1);
    endfunction

endpackage

// File: rtl/wdma_field_decode.sv
module wdma_field_decode
    import wdma_pkg::*;
#(
    parameter bit MEM_SIDE = 1'b0
) (
    input  seq_fields_t          fields,
    output logic [STEP_W-1:0]    step_bytes,
    output logic [BURST_W-1:0]   burst_words,
    output logic                 byte_swap,
    output logic                 dbl_buf,
    output logic [WRAP_W-1:0]    wrap_words,
    output logic                 cfg_err
);

    always_comb begin
        unique case (fields.width)
            3'd0:    step_bytes = STEP_W'(1);
            3'd1:    step_bytes = STEP_W'(2);
            3'd2:    step_bytes = STEP_W'(4);
            3'd3:    step_bytes = STEP_W'(8);
            3'd4:    step_bytes = STEP_W'(16);
            default: step_bytes = '0;
        endcase
    end

    assign byte_swap  = fields.swap;
    assign wrap_words = wrap_size(MEM_SIDE, fields.wrap);
    assign cfg_err    = fields_bad(MEM_SIDE, fields);

    generate
        if (MEM_SIDE) begin : g_mem
            always_comb begin
                unique case (fields.burst)
                    3'd4:    burst_words = BURST_W'(1);
                    3'd5:    burst_words = BURST_W'(4);
                    3'd6:    burst_words = BURST_W'(8);
                    default: burst_words = '0;
                endcase
            end
            assign dbl_buf = fields.dbuf;
        end else begin : g_per
            logic per_unused;
            assign per_unused  = ^{fields.burst, fields.dbuf};
            assign burst_words = '0;
            assign dbl_buf     = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/wdma_wrap_track.sv
module wdma_wrap_track
    import wdma_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [WRAP_W-1:0] wrap_words,
    output logic              hit
);

    logic [WRAP_W-1:0] cnt_q;

    // >= rather than == so that a shrunk window wraps on the next word.
    assign hit = (wrap_words != '0) && (cnt_q >= (wrap_words - WRAP_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (advance) begin
            if (hit)
                cnt_q <= '0;
            else if (wrap_words != '0)
                cnt_q <= cnt_q + WRAP_W'(1);
        end
    end

endmodule

// File: rtl/wdma_addr_seq.sv
module wdma_addr_seq
    import wdma_pkg::*;
#(
    parameter bit MEM_SIDE = 1'b0,
    parameter int ADDR_W   = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                seq_wr,
    input  logic [SEQ_W-1:0]    seq_data,
    input  logic                ptr_wr,
    input  logic [ADDR_W-1:0]   ptr_data,
    input  logic                xfer,
    output logic [ADDR_W-1:0]   addr,
    output logic [STEP_W-1:0]   step_bytes,
    output logic [BURST_W-1:0]  burst_words,
    output logic                byte_swap,
    output logic                dbl_buf,
    output logic [WRAP_W-1:0]   wrap_words,
    output logic                cfg_err,
    output logic                wrap_pulse
);

    localparam logic [SEQ_W-1:0] SEQ_RESET =
        MEM_SIDE ? (SEQ_W'(BURST_LO_CODE) << BURST_LSB) : '0;

    seq_state_e        state_q, state_d;
    seq_fields_t       fields_q, fields_d;
    logic [ADDR_W-1:0] addr_q, addr_d, base_q;
    logic              pulse_q, pulse_d;
    logic              advance, wrap_hit, bad_next;
    logic              seq_unused;

    assign seq_unused = ^{seq_data[31], seq_data[23:20], seq_data[15:0]};

    assign fields_d = seq_wr ? fields_of(seq_data) : fields_q;
    assign bad_next = fields_bad(MEM_SIDE, fields_d);

    wdma_field_decode #(.MEM_SIDE(MEM_SIDE)) u_dec (
        .fields      (fields_q),
        .step_bytes  (step_bytes),
        .burst_words (burst_words),
        .byte_swap   (byte_swap),
        .dbl_buf     (dbl_buf),
        .wrap_words  (wrap_words),
        .cfg_err     (cfg_err)
    );

    wdma_wrap_track u_wrap (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (ptr_wr),
        .advance    (advance),
        .wrap_words (wrap_words),
        .hit        (wrap_hit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (ptr_wr)    state_d = bad_next ? ST_HALT : ST_RUN;
            ST_RUN:  if (bad_next)  state_d = ST_HALT;
            ST_HALT: if (!bad_next) state_d = ST_RUN;
            default:                state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output and datapath logic
    always_comb begin
        advance = (state_q == ST_RUN) && xfer && !ptr_wr;
        pulse_d = advance && wrap_hit;
        addr_d  = addr_q;
        if (ptr_wr)
            addr_d = ptr_data;
        else if (advance)
            addr_d = wrap_hit ? base_q : addr_q + ADDR_W'(step_bytes);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields_q <= fields_of(SEQ_RESET);
            addr_q   <= '0;
            base_q   <= '0;
            pulse_q  <= 1'b0;
        end else begin
            fields_q <= fields_d;
            addr_q   <= addr_d;
            pulse_q  <= pulse_d;
            if (ptr_wr) base_q <= ptr_data;
        end
    end

    assign addr       = addr_q;
    assign wrap_pulse = pulse_q;

endmodule

// File: rtl/wdma_addr_seq_chk.sv
module wdma_addr_seq_chk
    import wdma_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ptr_wr,
    input logic [ADDR_W-1:0] ptr_data,
    input logic              xfer,
    input logic [ADDR_W-1:0] addr,
    input logic [STEP_W-1:0] step_bytes,
    input logic [WRAP_W-1:0] wrap_words,
    input logic              cfg_err,
    input logic              wrap_pulse,
    input seq_state_e        state,
    input logic              hit,
    input logic [ADDR_W-1:0] base
);

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !ptr_wr) |=> $stable(addr)); // R1

    AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(step_bytes)); // R2

    AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && xfer && !ptr_wr && !hit)
        |=> (addr - $past(addr)) == ADDR_W'($past(step_bytes))); // R3

    AST_WRAP_TO_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && xfer && !ptr_wr && hit)
        |=> (addr == $past(base)) && wrap_pulse); // R6

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_pulse |=> !wrap_pulse || $past(xfer)); // R6

    AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_wr |=> (addr == $past(ptr_data)) && !wrap_pulse); // R7

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_err && !ptr_wr) |=> $stable(addr)); // R8

    AST_RUN_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN) |-> !cfg_err); // R8

    AST_NO_WRAP_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap_words == '0) |=> !wrap_pulse); // R11

endmodule

bind wdma_addr_seq wdma_addr_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ptr_wr     (ptr_wr),
    .ptr_data   (ptr_data),
    .xfer       (xfer),
    .addr       (addr),
    .step_bytes (step_bytes),
    .wrap_words (wrap_words),
    .cfg_err    (cfg_err),
    .wrap_pulse (wrap_pulse),
    .state      (state_q),
    .hit        (wrap_hit),
    .base       (base_q)
);

// File: tb/sim_wdma_addr_seq.sv
module sim_wdma_addr_seq;
    import wdma_pkg::*;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst_n, seq_wr, ptr_wr, xfer;
    logic [31:0] seq_data, ptr_data;

    logic [31:0] a0, a1;
    logic [4:0]  st0, st1;
    logic [3:0]  bu0, bu1;
    logic        sw0, sw1, db0, db1, er0, er1, wp0, wp1;
    logic [11:0] ww0, ww1;

    int n_chk = 0;
    int n_bad = 0;

    wdma_addr_seq #(.MEM_SIDE(1'b0), .ADDR_W(32)) u0 (
        .clk(clk), .rst_n(rst_n), .seq_wr(seq_wr), .seq_data(seq_data),
        .ptr_wr(ptr_wr), .ptr_data(ptr_data), .xfer(xfer),
        .addr(a0), .step_bytes(st0), .burst_words(bu0), .byte_swap(sw0),
        .dbl_buf(db0), .wrap_words(ww0), .cfg_err(er0), .wrap_pulse(wp0));

    wdma_addr_seq #(.MEM_SIDE(1'b1), .ADDR_W(32)) u1 (
        .clk(clk), .rst_n(rst_n), .seq_wr(seq_wr), .seq_data(seq_data),
        .ptr_wr(ptr_wr), .ptr_data(ptr_data), .xfer(xfer),
        .addr(a1), .step_bytes(st1), .burst_words(bu1), .byte_swap(sw1),
        .dbl_buf(db1), .wrap_words(ww1), .cfg_err(er1), .wrap_pulse(wp1));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input int w, input int b, input int swp,
                                       input int dbf, input int wr);
        return (32'(w) << 28) | (32'(swp) << 27) | (32'(b) << 24) |
               (32'(dbf) << 19) | (32'(wr) << 16);
    endfunction

    task automatic wr_seq(input logic [31:0] v);
        @(negedge clk); seq_wr = 1'b1; seq_data = v;
        @(negedge clk); seq_wr = 1'b0;
    endtask

    task automatic wr_ptr(input logic [31:0] v);
        @(negedge clk); ptr_wr = 1'b1; ptr_data = v;
        @(negedge clk); ptr_wr = 1'b0;
    endtask

    task automatic xfer1();
        @(negedge clk); xfer = 1'b1;
        @(negedge clk); xfer = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog (all): actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int w0, w1, n;
        logic [31:0] base, e0, e1;
        rst_n = 1'b0; seq_wr = 1'b0; ptr_wr = 1'b0; xfer = 1'b0;
        seq_data = '0; ptr_data = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 addr u0", a0, 0);           chk("R1 addr u1", a1, 0);
        chk("R1 pulse u0", 32'(wp0), 0);    chk("R1 pulse u1", 32'(wp1), 0);
        chk("R1 err u0", 32'(er0), 0);      chk("R1 err u1", 32'(er1), 0);
        chk("R1 step u0", 32'(st0), 1);     chk("R1 wrap u1", 32'(ww1), 0);
        xfer1();
        chk("R1 idle hold u0", a0, 0);      chk("R1 idle hold u1", a1, 0);

        // R2 / R3 width sweep
        for (int w = 0; w < 5; w++) begin
            wr_seq(mk(w, 4, 0, 0, 0));
            chk("R2 step u0", 32'(st0), 32'(1) << w);
            chk("R2 step u1", 32'(st1), 32'(1) << w);
            wr_ptr(32'h1000);
            for (int k = 1; k <= 5; k++) begin
                xfer1();
                chk("R3 addr u0", a0, 32'h1000 + 32'(k) * (32'(1) << w));
                chk("R3 addr u1", a1, 32'h1000 + 32'(k) * (32'(1) << w));
            end
        end

        // R4 R5 R6 R11 wrap sweep
        for (int c = 0; c < 8; c++) begin
            w0 = (c == 0) ? 0 : (1 << (c - 1));
            w1 = (c == 0) ? 0 : (32 << (c - 1));
            wr_seq(mk(2, 4, 0, 0, c));
            chk("R4 wrap size u0", 32'(ww0), 32'(w0));
            chk("R5 wrap size u1", 32'(ww1), 32'(w1));
            base = 32'h0002_0000 + 32'(c) * 32'h100;
            wr_ptr(base);
            n = (c == 0) ? 10 : ((w0 > w1 ? w0 : w1) + 3);
            for (int k = 1; k <= n; k++) begin
                xfer1();
                e0 = (w0 == 0) ? base + 32'(k) * 4 : base + 32'(k % w0) * 4;
                e1 = (w1 == 0) ? base + 32'(k) * 4 : base + 32'(k % w1) * 4;
                chk(c == 0 ? "R11 addr u0" : "R6 addr u0", a0, e0);
                chk(c == 0 ? "R11 addr u1" : "R6 addr u1", a1, e1);
                chk("R6 pulse u0", 32'(wp0), 32'((w0 != 0) && (k % w0 == 0)));
                chk("R6 pulse u1", 32'(wp1), 32'((w1 != 0) && (k % w1 == 0)));
            end
        end

        // R7 pointer write beats a same-cycle transfer and clears the count
        wr_seq(mk(2, 4, 0, 0, 3));
        wr_ptr(32'h3000);
        xfer1(); xfer1();
        chk("R7 pre u0", a0, 32'h3008);
        @(negedge clk); ptr_wr = 1'b1; ptr_data = 32'h4000; xfer = 1'b1;
        @(negedge clk); ptr_wr = 1'b0; xfer = 1'b0;
        chk("R7 load u0", a0, 32'h4000);    chk("R7 load u1", a1, 32'h4000);
        xfer1(); xfer1(); xfer1();
        chk("R7 count u0", a0, 32'h400C);
        xfer1();
        chk("R7 wrap u0", a0, 32'h4000);    chk("R7 pulse u0", 32'(wp0), 1);
        chk("R7 no wrap u1", a1, 32'h4010);

        // R12 window shrunk below the count reached
        wr_seq(mk(2, 4, 0, 0, 5));
        wr_ptr(32'h5000);
        for (int k = 0; k < 10; k++) xfer1();
        chk("R12 pre u0", a0, 32'h5028);
        wr_seq(mk(2, 4, 0, 0, 3));
        xfer1();
        chk("R12 wrap u0", a0, 32'h5000);   chk("R12 pulse u0", 32'(wp0), 1);
        chk("R12 u1 runs on", a1, 32'h502C);

        // R8 illegal width holds the pointer
        wr_seq(mk(2, 4, 0, 0, 0));
        wr_ptr(32'h6000);
        wr_seq(mk(5, 4, 0, 0, 0));
        chk("R8 err u0", 32'(er0), 1);      chk("R8 err u1", 32'(er1), 1);
        xfer1();
        chk("R8 hold u0", a0, 32'h6000);    chk("R8 hold u1", a1, 32'h6000);
        wr_seq(mk(7, 4, 0, 0, 0));
        chk("R8 err w7 u0", 32'(er0), 1);
        wr_seq(mk(1, 4, 0, 0, 0));
        chk("R8 clear u0", 32'(er0), 0);
        xfer1();
        chk("R8 resume u0", a0, 32'h6002); chk("R8 resume u1", a1, 32'h6002);

        // R9 burst decode and side-specific legality
        for (int b = 4; b < 7; b++) begin
            wr_seq(mk(2, b, 0, 0, 0));
            chk("R9 burst u1", 32'(bu1), (b == 4) ? 1 : (b == 5) ? 4 : 8);
            chk("R9 burst u0", 32'(bu0), 0);
            chk("R9 err u1", 32'(er1), 0);
        end
        wr_ptr(32'h7000);
        wr_seq(mk(2, 7, 0, 0, 0));
        chk("R9 bad burst u1", 32'(er1), 1);
        chk("R9 ignored u0", 32'(er0), 0);
        xfer1();
        chk("R9 hold u1", a1, 32'h7000);    chk("R9 run u0", a0, 32'h7004);
        wr_seq(mk(2, 0, 0, 0, 0));
        chk("R9 burst0 u1", 32'(er1), 1);

        // R10 swap and double-buffer bits
        wr_seq(mk(2, 4, 1, 1, 0));
        chk("R10 swap u0", 32'(sw0), 1);    chk("R10 swap u1", 32'(sw1), 1);
        chk("R10 dbuf u1", 32'(db1), 1);    chk("R10 dbuf u0", 32'(db0), 0);
        wr_seq(mk(2, 4, 0, 0, 0));
        chk("R10 swap off u0", 32'(sw0), 0); chk("R10 dbuf off u1", 32'(db1), 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule